// File: doc/BRIEF.md
# Power-Managed Clock Source Controller

This block decides which oscillator clocks the device and which oscillators are allowed to run, across seven power modes. Each of three clock families has a run mode and an idle mode: the primary oscillator, the low-speed secondary oscillator, and the internal oscillator block. A sleep mode stops every source except those that an always-on feature still needs. The oscillators are modelled by their enable outputs. The block's own clock `clk_i` stands in for the 16 MHz high-frequency internal oscillator that feeds the postscaler.

A mode is requested by pulsing `mode_set_i` with a 3-bit code on `mode_req_i`. A wake event on `wake_i` returns an idle or sleeping device to the run mode of the family it was using. Features that need the 31 kHz low-frequency internal oscillator, such as the watchdog, raise bits of `lf_req_i`. Timer peripherals that need the secondary oscillator raise bits of `sec_req_i`. When `lf_direct_i` is set, the low-frequency internal output clocks the device directly and the high-frequency internal oscillator is switched off. The high-frequency output also feeds a power-of-two postscaler. The postscaler produces a one-cycle-wide divided clock pulse on `hf_div_o`, and it changes its ratio only at the end of a full output period.

Top module: `pm_clk_ctrl`

## Requirements
- R1: After reset the mode is primary run. `pri_en_o`, `cpu_ce_o` and `per_ce_o` are 1, `src_sel_o` is 0, and `sec_en_o`, `lf_en_o` and `hf_en_o` are 0 when no feature requests are present.
- R2: A pulse on `mode_set_i` loads the mode code on `mode_req_i` at the next clock edge. The codes are 0 primary run, 1 primary idle, 2 secondary run, 3 secondary idle, 4 internal run, 5 internal idle and 6 sleep. Code 7 is ignored and leaves the mode unchanged. When `mode_set_i` and `wake_i` arrive in the same cycle, the request wins. With neither input present, the mode holds.
- R3: `pri_en_o` is 1 only in primary run and primary idle.
- R4: `sec_en_o` is 1 in secondary run and secondary idle. It is also 1 in any mode, sleep included, while any bit of `sec_req_i` is 1.
- R5: `lf_en_o` is 1 in any mode, sleep included, while any bit of `lf_req_i` is 1. It is also 1 in internal run and internal idle while `lf_direct_i` is 1.
- R6: `hf_en_o` is 1 only in internal run and internal idle while `lf_direct_i` is 0. It is 0 whenever the device clock comes directly from the low-frequency output.
- R7: `cpu_ce_o` is 1 only in run modes. `per_ce_o` is 1 in run and idle modes. Both are 0 in sleep.
- R8: `src_sel_o` gives the device clock source: 0 primary, 1 secondary, 2 high-frequency internal, 3 low-frequency internal (internal family with `lf_direct_i` = 1). In sleep it keeps the family that was in use before sleep.
- R9: `wake_i` in an idle mode moves to the run mode of the same family. In sleep it moves to the run mode of the family in use before sleep. In a run mode it has no effect.
- R10: While `hf_en_o` is 1, `hf_div_o` is high for one cycle in every 2^`ps_sel_i` cycles. A value of 0 keeps it high in every cycle. While `hf_en_o` is 0, `hf_div_o` stays 0.
- R11: A new `ps_sel_i` value takes effect only after the pulse that ends the current output period, so that period finishes at the old ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, models the high-frequency internal oscillator |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_set_i | input | 1 | Mode request strobe |
| mode_req_i | input | 3 | Requested mode code |
| wake_i | input | 1 | Wake event |
| lf_direct_i | input | 1 | Internal family clocks directly from the low-frequency output |
| sec_req_i | input | SEC_REQ_W | Per-peripheral requests to keep the secondary oscillator on |
| lf_req_i | input | LF_REQ_W | Per-feature requests to keep the low-frequency internal oscillator on |
| ps_sel_i | input | PS_SEL_W | Postscaler exponent, divide by 2^value |
| pri_en_o | output | 1 | Primary oscillator enable |
| sec_en_o | output | 1 | Secondary oscillator enable |
| lf_en_o | output | 1 | Low-frequency internal oscillator enable |
| hf_en_o | output | 1 | High-frequency internal oscillator enable |
| cpu_ce_o | output | 1 | CPU clock enable |
| per_ce_o | output | 1 | Peripheral clock enable |
| src_sel_o | output | 2 | Device clock source select |
| hf_div_o | output | 1 | Divided high-frequency clock pulse |

## Verification
The whole mode state sits in one register and the last-family record. A wrong mode shows at the ports on the first edge after a request or wake event, as a wrong pattern on the enables and on `src_sel_o`. A lost family record stays hidden through sleep and appears only at wake, as a run mode of the wrong family. For that reason the bench wakes from sleep from more than one family. A wrong postscaler count or ratio-load point shows only in pulse spacing, and may take up to one full old period to appear. The bench therefore measures pulse counts over whole windows and the exact gap across a ratio change.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [2:0] {
    M_PRI_RUN  = 3'd0,
    M_PRI_IDLE = 3'd1,
    M_SEC_RUN  = 3'd2,
    M_SEC_IDLE = 3'd3,
    M_INT_RUN  = 3'd4,
    M_INT_IDLE = 3'd5,
    M_SLEEP    = 3'd6
  } pm_mode_e;

  typedef enum logic [1:0] {
    FAM_PRI = 2'd0,
    FAM_SEC = 2'd1,
    FAM_INT = 2'd2
  } fam_e;

  localparam logic [2:0] MODE_RSVD = 3'd7;

  localparam logic [1:0] SRC_PRI = 2'd0;
  localparam logic [1:0] SRC_SEC = 2'd1;
  localparam logic [1:0] SRC_HFI = 2'd2;
  localparam logic [1:0] SRC_LFI = 2'd3;

  function automatic logic is_sleep(pm_mode_e m);
    return m == M_SLEEP;
  endfunction

  function automatic logic is_idle(pm_mode_e m);
    return (m != M_SLEEP) && m[0];
  endfunction

  function automatic logic is_run(pm_mode_e m);
    return (m != M_SLEEP) && !m[0];
  endfunction

  function automatic pm_mode_e run_of(fam_e f);
    return pm_mode_e'({f, 1'b0});
  endfunction
endpackage

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       set_i,
  input  logic [2:0] req_i,
  input  logic       wake_i,
  output pm_mode_e   mode_o,
  output fam_e       fam_o
);
  pm_mode_e mode_q, mode_d;
  fam_e     fam_q, fam_d;

  always_comb begin
    mode_d = mode_q;
    if (set_i) begin
      if (req_i != MODE_RSVD) mode_d = pm_mode_e'(req_i);
    end else if (wake_i) begin
      if (is_sleep(mode_q))     mode_d = run_of(fam_q);
      else if (is_idle(mode_q)) mode_d = pm_mode_e'({mode_q[2:1], 1'b0});
    end
    // family record survives sleep so wake knows where to return
    fam_d = fam_q;
    if (!is_sleep(mode_d)) fam_d = fam_e'(mode_d[2:1]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= M_PRI_RUN;
      fam_q  <= FAM_PRI;
    end else begin
      mode_q <= mode_d;
      fam_q  <= fam_d;
    end
  end

  assign mode_o = mode_q;
  assign fam_o  = fam_q;
endmodule

// File: rtl/pmc_osc_gate.sv
module pmc_osc_gate
  import pmc_pkg::*;
#(
  parameter int SEC_REQ_W = 2,
  parameter int LF_REQ_W  = 2
) (
  input  pm_mode_e             mode_i,
  input  fam_e                 fam_i,
  input  logic                 lf_direct_i,
  input  logic [SEC_REQ_W-1:0] sec_req_i,
  input  logic [LF_REQ_W-1:0]  lf_req_i,
  output logic                 pri_en_o,
  output logic                 sec_en_o,
  output logic                 lf_en_o,
  output logic                 hf_en_o,
  output logic                 cpu_ce_o,
  output logic                 per_ce_o,
  output logic [1:0]           src_sel_o
);
  logic fam_pri_act, fam_sec_act, fam_int_act;
  logic sec_keep, lf_keep;

  // family active only outside sleep
  assign fam_pri_act = (mode_i == M_PRI_RUN) || (mode_i == M_PRI_IDLE);
  assign fam_sec_act = (mode_i == M_SEC_RUN) || (mode_i == M_SEC_IDLE);
  assign fam_int_act = (mode_i == M_INT_RUN) || (mode_i == M_INT_IDLE);

  assign sec_keep = |sec_req_i;
  assign lf_keep  = |lf_req_i;

  assign pri_en_o = fam_pri_act;
  assign sec_en_o = fam_sec_act || sec_keep;
  assign lf_en_o  = lf_keep || (fam_int_act && lf_direct_i);
  assign hf_en_o  = fam_int_act && !lf_direct_i;

  assign cpu_ce_o = is_run(mode_i);
  assign per_ce_o = !is_sleep(mode_i);

  always_comb begin
    unique case (fam_i)
      FAM_PRI: src_sel_o = SRC_PRI;
      FAM_SEC: src_sel_o = SRC_SEC;
      default: src_sel_o = lf_direct_i ? SRC_LFI : SRC_HFI;
    endcase
  end
endmodule

// File: rtl/pmc_postscaler.sv
module pmc_postscaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int MAX_EXP = (1 << SEL_W) - 1;
  localparam int CNT_W   = (MAX_EXP > 0) ? MAX_EXP : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [SEL_W-1:0] exp_q;
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] lim;
  logic             hit;

  assign span = {{CNT_W{1'b0}}, 1'b1} << exp_q;
  assign lim  = CNT_W'(span - 1'b1);
  assign hit  = run_i && (cnt_q == lim);

  // ratio reloads only at a period boundary or while stopped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      exp_q <= '0;
    end else if (!run_i || hit) begin
      cnt_q <= '0;
      exp_q <= sel_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick_o = hit;
endmodule

// File: rtl/pm_clk_ctrl.sv
module pm_clk_ctrl
  import pmc_pkg::*;
#(
  parameter int SEC_REQ_W = 2,
  parameter int LF_REQ_W  = 2,
  parameter int PS_SEL_W  = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 mode_set_i,
  input  logic [2:0]           mode_req_i,
  input  logic                 wake_i,
  input  logic                 lf_direct_i,
  input  logic [SEC_REQ_W-1:0] sec_req_i,
  input  logic [LF_REQ_W-1:0]  lf_req_i,
  input  logic [PS_SEL_W-1:0]  ps_sel_i,
  output logic                 pri_en_o,
  output logic                 sec_en_o,
  output logic                 lf_en_o,
  output logic                 hf_en_o,
  output logic                 cpu_ce_o,
  output logic                 per_ce_o,
  output logic [1:0]           src_sel_o,
  output logic                 hf_div_o
);
  pm_mode_e mode;
  fam_e     fam;
  logic     hf_en;

  pmc_mode_fsm u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (mode_set_i),
    .req_i  (mode_req_i),
    .wake_i (wake_i),
    .mode_o (mode),
    .fam_o  (fam)
  );

  pmc_osc_gate #(
    .SEC_REQ_W (SEC_REQ_W),
    .LF_REQ_W  (LF_REQ_W)
  ) u_gate (
    .mode_i      (mode),
    .fam_i       (fam),
    .lf_direct_i (lf_direct_i),
    .sec_req_i   (sec_req_i),
    .lf_req_i    (lf_req_i),
    .pri_en_o    (pri_en_o),
    .sec_en_o    (sec_en_o),
    .lf_en_o     (lf_en_o),
    .hf_en_o     (hf_en),
    .cpu_ce_o    (cpu_ce_o),
    .per_ce_o    (per_ce_o),
    .src_sel_o   (src_sel_o)
  );

  pmc_postscaler #(
    .SEL_W (PS_SEL_W)
  ) u_ps (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (hf_en),
    .sel_i  (ps_sel_i),
    .tick_o (hf_div_o)
  );

  assign hf_en_o = hf_en;
endmodule

// File: rtl/pm_clk_ctrl_chk.sv
module pm_clk_ctrl_chk #(
  parameter int LF_REQ_W = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                mode_set_i,
  input logic                wake_i,
  input logic                lf_direct_i,
  input logic [LF_REQ_W-1:0] lf_req_i,
  input logic                pri_en_o,
  input logic                sec_en_o,
  input logic                lf_en_o,
  input logic                hf_en_o,
  input logic                cpu_ce_o,
  input logic                per_ce_o,
  input logic [1:0]          src_sel_o,
  input logic                hf_div_o
);
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_set_i && !wake_i) |=> ($stable(cpu_ce_o) && $stable(per_ce_o) && $stable(pri_en_o)));

  p_pri_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pri_en_o |-> (src_sel_o == 2'd0 && per_ce_o));

  p_sec_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_ce_o && src_sel_o == 2'd1) |-> sec_en_o);

  p_lf_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|lf_req_i) |-> lf_en_o);

  p_hf_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hf_en_o |-> (!lf_direct_i && src_sel_o == 2'd2 && per_ce_o));

  p_ce_order_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ce_o |-> per_ce_o);

  p_wake_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_i && !mode_set_i && !cpu_ce_o) |=> cpu_ce_o);

  p_div_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hf_div_o |-> hf_en_o);
endmodule

bind pm_clk_ctrl pm_clk_ctrl_chk #(
  .LF_REQ_W (LF_REQ_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_set_i  (mode_set_i),
  .wake_i      (wake_i),
  .lf_direct_i (lf_direct_i),
  .lf_req_i    (lf_req_i),
  .pri_en_o    (pri_en_o),
  .sec_en_o    (sec_en_o),
  .lf_en_o     (lf_en_o),
  .hf_en_o     (hf_en_o),
  .cpu_ce_o    (cpu_ce_o),
  .per_ce_o    (per_ce_o),
  .src_sel_o   (src_sel_o),
  .hf_div_o    (hf_div_o)
);

// File: tb/sim_pm_clk_ctrl.sv
`timescale 1ns/1ps
module sim_pm_clk_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SEC_REQ_W  = 2;
  localparam int LF_REQ_W   = 2;
  localparam int PS_SEL_W   = 3;

  logic                 clk = 1'b0;
  logic                 rst_ni = 1'b0;
  logic                 mode_set = 1'b0;
  logic [2:0]           mode_req = 3'd0;
  logic                 wake = 1'b0;
  logic                 lfd = 1'b0;
  logic [SEC_REQ_W-1:0] sec_req = '0;
  logic [LF_REQ_W-1:0]  lf_req = '0;
  logic [PS_SEL_W-1:0]  ps_sel = '0;
  logic pri_en, sec_en, lf_en, hf_en, cpu_ce, per_ce, hf_div;
  logic [1:0] src_sel;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pm_clk_ctrl #(
    .SEC_REQ_W (SEC_REQ_W),
    .LF_REQ_W  (LF_REQ_W),
    .PS_SEL_W  (PS_SEL_W)
  ) u0 (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .mode_set_i  (mode_set),
    .mode_req_i  (mode_req),
    .wake_i      (wake),
    .lf_direct_i (lfd),
    .sec_req_i   (sec_req),
    .lf_req_i    (lf_req),
    .ps_sel_i    (ps_sel),
    .pri_en_o    (pri_en),
    .sec_en_o    (sec_en),
    .lf_en_o     (lf_en),
    .hf_en_o     (hf_en),
    .cpu_ce_o    (cpu_ce),
    .per_ce_o    (per_ce),
    .src_sel_o   (src_sel),
    .hf_div_o    (hf_div)
  );

  // scoreboard: {pri,sec,lf,hf,cpu,per,src[1:0]}
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] mon_exp, mon_act;
  string      mon_tag;

  int bm = 0;  // bench model mode
  int bf = 0;  // bench model family

  function automatic logic [7:0] predict();
    logic p, s, l, h, c, q;
    logic [1:0] src;
    logic int_fam;
    int_fam = (bm == 4) || (bm == 5);
    p = (bm == 0) || (bm == 1);
    s = (bm == 2) || (bm == 3) || (|sec_req);
    l = (|lf_req) || (int_fam && lfd);
    h = int_fam && !lfd;
    c = (bm == 0) || (bm == 2) || (bm == 4);
    q = (bm != 6);
    src = (bf == 0) ? 2'd0 : (bf == 1) ? 2'd1 : (lfd ? 2'd3 : 2'd2);
    return {p, s, l, h, c, q, src};
  endfunction

  task automatic step(input logic set, input logic [2:0] req, input logic wk, input string tag);
    @(negedge clk);
    mode_set = set;
    mode_req = req;
    wake = wk;
    if (set) begin
      if (req != 3'd7) bm = int'(req);
    end else if (wk) begin
      if (bm == 6) bm = bf * 2;
      else if (bm % 2 == 1) bm = bm - 1;
    end
    if (bm != 6) bf = bm / 2;
    exp_q.push_back(predict());
    tag_q.push_back(tag);
    @(posedge clk);
    #2;
    mode_set = 1'b0;
    wake = 1'b0;
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      mon_exp = exp_q.pop_front();
      mon_tag = tag_q.pop_front();
      mon_act = {pri_en, sec_en, lf_en, hf_en, cpu_ce, per_ce, src_sel};
      checks++;
      if (mon_act !== mon_exp) begin
        errors++;
        $display("FAIL %s: act=%b exp=%b", mon_tag, mon_act, mon_exp);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp_v);
    end
  endtask

  task automatic wait_pulse();
    do begin
      @(posedge clk);
      #1;
    end while (!hf_div);
  endtask

  task automatic count_pulses(input int n, output int cnt);
    cnt = 0;
    repeat (n) begin
      @(posedge clk);
      #1;
      if (hf_div) cnt++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, gap;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;

    step(1'b0, 3'd0, 1'b0, "R1 reset state primary run");
    step(1'b1, 3'd1, 1'b0, "R3 primary idle keeps primary on");
    step(1'b0, 3'd0, 1'b1, "R9 wake from primary idle");
    step(1'b0, 3'd0, 1'b1, "R9 wake in run has no effect");
    step(1'b1, 3'd2, 1'b0, "R4 secondary run");
    step(1'b1, 3'd3, 1'b0, "R4 secondary idle");
    sec_req = 2'b10;
    lf_req  = 2'b01;
    step(1'b1, 3'd6, 1'b0, "R4 R5 sleep keeps requested oscillators");
    sec_req = '0;
    lf_req  = '0;
    step(1'b0, 3'd0, 1'b0, "R7 R8 sleep stops all and holds source");
    step(1'b0, 3'd0, 1'b1, "R9 wake from sleep to secondary run");
    step(1'b1, 3'd7, 1'b0, "R2 reserved code ignored");
    step(1'b1, 3'd0, 1'b0, "R3 primary run");
    lfd = 1'b0;
    step(1'b1, 3'd4, 1'b0, "R6 internal run on high-frequency source");
    lfd = 1'b1;
    step(1'b0, 3'd0, 1'b0, "R6 R8 low-frequency direct turns high-frequency off");
    step(1'b1, 3'd5, 1'b1, "R2 request beats wake in same cycle");
    lfd = 1'b0;
    step(1'b1, 3'd6, 1'b0, "R8 sleep holds internal source");
    step(1'b0, 3'd0, 1'b1, "R9 wake from sleep to internal run");

    // postscaler, internal run with high-frequency source
    ps_sel = 3'd2;
    wait_pulse();
    wait_pulse();
    count_pulses(64, n);
    chk("R10 divide by 4 pulse count", n, 16);
    ps_sel = 3'd0;
    wait_pulse();
    wait_pulse();
    count_pulses(64, n);
    chk("R10 divide by 1 pulse count", n, 64);
    ps_sel = 3'd7;
    wait_pulse();
    wait_pulse();
    count_pulses(256, n);
    chk("R10 divide by 128 pulse count", n, 2);

    ps_sel = 3'd3;
    wait_pulse();
    wait_pulse();
    wait_pulse();
    @(posedge clk);
    @(negedge clk);
    ps_sel = 3'd0;
    gap = 1;
    do begin
      @(posedge clk);
      #1;
      gap++;
    end while (!hf_div);
    chk("R11 period in flight keeps old ratio", gap, 8);
    @(posedge clk);
    #1;
    chk("R11 new ratio after boundary", int'(hf_div), 1);

    step(1'b1, 3'd0, 1'b0, "R6 primary run high-frequency off");
    count_pulses(40, n);
    chk("R10 no divided pulse while high-frequency off", n, 0);

    @(posedge clk);
    #3;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule